// File: doc/BRIEF.md
# Qualified Performance Event Counter

This block is one hardware performance-monitoring counter. Each clock it receives a count of how many times the monitored event happened in that cycle, together with the privilege ring the core is running in. A small control register decides whether that cycle adds to the count. The decision can use an occurrence threshold, can invert the result, can count only rising edges of the result, and can filter by privilege ring. A 48-bit accumulator then advances by the amount the qualifier allows.

Software can load the accumulator at any time and read it back continuously. A sticky flag records that the accumulator has wrapped past its all-ones value. Event selection, interrupt signalling and any register-access bus wrapper belong to the surrounding logic.

Top module: `evt_qual_counter`

## Requirements
- R1: After reset the counter reads 0, the overflow flag reads 0 and the control register is 0. With that control value, no input pattern changes the counter.
- R2: Control bit 0 is a master enable; with it clear nothing counts. Ring value 0 counts only when control bit 2 (kernel enable) is set. Ring values 1, 2 and 3 count only when control bit 1 (user enable) is set. A control write takes effect from the cycle after the write.
- R3: With threshold (control bits 12:5) equal to 0, invert (bit 3) clear and edge detect (bit 4) clear, the counter adds the raw 4-bit occurrence value, from 0 to 15, every eligible cycle.
- R4: With a nonzero threshold, an eligible cycle adds exactly 1 when the occurrence value is greater than or equal to the threshold, and adds 0 otherwise.
- R5: With invert set, the cycle condition is negated and an eligible cycle adds 1 when the condition is false. With a threshold of 0 the condition is "occurrence nonzero". With a nonzero threshold it is "occurrence at least the threshold".
- R6: With edge detect set and a nonzero threshold, the counter adds 1 only in a cycle whose qualified result is true while the previous cycle's result was false. The previous result resets to 0 and is updated every cycle, including cycles blocked by the ring filter or the master enable.
- R7: With edge detect set and a threshold of 0, the configuration is invalid and the counter does not advance.
- R8: A counter write makes the written value appear on the counter output the next cycle. Any increment from the same cycle is discarded.
- R9: The overflow flag sets when an increment carries out of bit 47 and then holds until an overflow clear. If a wrap and a clear happen in the same cycle, the flag ends up set. A counter write never sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| occ_i | input | 4 | Event occurrences in this cycle |
| ring_i | input | 2 | Current privilege ring (0 = kernel) |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 13 | Control value: bit0 enable, bit1 user, bit2 kernel, bit3 invert, bit4 edge, bits 12:5 threshold |
| cnt_we_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | 48 | Value loaded into the counter |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| cnt_o | output | 48 | Current counter value |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The hardest case to reach is the edge-detect history crossing a ring change. The qualified result has to go true during a kernel-ring cycle while only user counting is enabled, and the following user-ring cycle must then add nothing. The stimulus builds this by holding the occurrence value at or above the threshold across the ring switch, with the kernel enable cleared. Reaching a wrap from the ports is done by loading the counter a few counts below all ones and then feeding a large occurrence value. That also creates the wrap-plus-clear collision in a single cycle.

// File: rtl/evt_qual_pkg.sv
package evt_qual_pkg;

   localparam int THR_W  = 8;
   localparam int CFG_W  = THR_W + 5;

   // Control word layout, LSB first: enable, user, kernel, invert, edge, threshold.
   typedef struct packed {
      logic [THR_W-1:0] thr;
      logic             edge_det;
      logic             inv;
      logic             krn;
      logic             usr;
      logic             en;
   } qual_cfg_t;

endpackage

// File: rtl/evt_qual_ring.sv
module evt_qual_ring #(
   parameter int RING_W = 2
) (
   input  logic [RING_W-1:0] ring_i,
   input  logic              usr_i,
   input  logic              krn_i,
   output logic              pass_o
);

   localparam logic [RING_W-1:0] KRN_RING = '0;

   logic at_krn;

   generate
      if (RING_W == 1) begin : g_one_bit
         assign at_krn = ~ring_i[0];
      end else begin : g_multi_bit
         assign at_krn = (ring_i == KRN_RING);
      end
   endgenerate

   assign pass_o = at_krn ? krn_i : usr_i;

endmodule

// File: rtl/evt_qual_cond.sv
module evt_qual_cond #(
   parameter int OCC_W    = 4,
   parameter int THR_W    = 8,
   parameter bit HAS_EDGE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OCC_W-1:0] occ_i,
   input  logic [THR_W-1:0] thr_i,
   input  logic             inv_i,
   input  logic             edge_det_i,
   input  logic             count_en_i,
   output logic [OCC_W-1:0] amt_o
);

   localparam int CMP_W = (OCC_W > THR_W) ? OCC_W : THR_W;
   localparam logic [OCC_W-1:0] ONE = OCC_W'(1);

   logic [CMP_W-1:0] occ_x;
   logic [CMP_W-1:0] thr_x;
   logic             thr_zero;
   logic             cond;
   logic             qual;
   logic             mode_edge;
   logic             edge_hit;

   assign occ_x    = CMP_W'(occ_i);
   assign thr_x    = CMP_W'(thr_i);
   assign thr_zero = (thr_i == '0);
   assign cond     = thr_zero ? (occ_i != '0) : (occ_x >= thr_x);
   assign qual     = cond ^ inv_i;

   generate
      if (HAS_EDGE) begin : g_edge
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= qual;
         end
         assign mode_edge = edge_det_i;
         assign edge_hit  = qual & ~prev_q & ~thr_zero;
      end else begin : g_level
         assign mode_edge = 1'b0;
         assign edge_hit  = 1'b0;
      end
   endgenerate

   always_comb begin
      if (!count_en_i)             amt_o = '0;
      else if (mode_edge)          amt_o = edge_hit ? ONE : '0;
      else if (thr_zero && !inv_i) amt_o = occ_i;
      else                         amt_o = qual ? ONE : '0;
   end

   AST_EDGE_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_det_i && amt_o != '0) |=> (!edge_det_i || amt_o == '0)); // R6
   AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_det_i && HAS_EDGE) |-> (amt_o <= ONE)); // R6

endmodule

// File: rtl/evt_qual_accum.sv
module evt_qual_accum #(
   parameter int CNT_W  = 48,
   parameter int STEP_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STEP_W-1:0] step_i,
   input  logic              wr_en_i,
   input  logic [CNT_W-1:0]  wr_data_i,
   input  logic              ovf_clr_i,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              ovf_o
);

   localparam int PAD_W = CNT_W + 1 - STEP_W;

   logic [CNT_W-1:0] cnt_q;
   logic             ovf_q;
   logic [CNT_W:0]   sum_w;

   assign sum_w = {1'b0, cnt_q} + {{PAD_W{1'b0}}, step_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         cnt_q <= wr_en_i ? wr_data_i : sum_w[CNT_W-1:0];
         ovf_q <= (~wr_en_i & sum_w[CNT_W]) | (ovf_q & ~ovf_clr_i);
      end
   end

   assign cnt_o = cnt_q;
   assign ovf_o = ovf_q;

   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> (cnt_o == $past(wr_data_i))); // R8
   AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o && !ovf_clr_i) |=> ovf_o); // R9
   AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en_i && cnt_o == '1 && step_i != '0) |=> ovf_o); // R9

endmodule

// File: rtl/evt_qual_counter.sv
module evt_qual_counter
   import evt_qual_pkg::*;
#(
   parameter int OCC_W    = 4,
   parameter int RING_W   = 2,
   parameter int CNT_W    = 48,
   parameter bit HAS_EDGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OCC_W-1:0]  occ_i,
   input  logic [RING_W-1:0] ring_i,
   input  logic              cfg_we_i,
   input  logic [CFG_W-1:0]  cfg_wdata_i,
   input  logic              cnt_we_i,
   input  logic [CNT_W-1:0]  cnt_wdata_i,
   input  logic              ovf_clr_i,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              ovf_o
);

   initial begin : p_param_chk
      assert (CNT_W > OCC_W) else $fatal(1, "counter narrower than step");
      assert (OCC_W >= 1 && RING_W >= 1) else $fatal(1, "bad port width");
   end

   qual_cfg_t        cfg_q;
   logic             ring_pass;
   logic             count_en;
   logic [OCC_W-1:0] amt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cfg_q <= '0;
      else if (cfg_we_i) cfg_q <= qual_cfg_t'(cfg_wdata_i);
   end

   evt_qual_ring #(.RING_W(RING_W)) u_ring (
      .ring_i (ring_i),
      .usr_i  (cfg_q.usr),
      .krn_i  (cfg_q.krn),
      .pass_o (ring_pass)
   );

   assign count_en = cfg_q.en & ring_pass;

   evt_qual_cond #(.OCC_W(OCC_W), .THR_W(THR_W), .HAS_EDGE(HAS_EDGE)) u_cond (
      .clk        (clk),
      .rst_n      (rst_n),
      .occ_i      (occ_i),
      .thr_i      (cfg_q.thr),
      .inv_i      (cfg_q.inv),
      .edge_det_i (cfg_q.edge_det),
      .count_en_i (count_en),
      .amt_o      (amt)
   );

   evt_qual_accum #(.CNT_W(CNT_W), .STEP_W(OCC_W)) u_accum (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_i    (amt),
      .wr_en_i   (cnt_we_i),
      .wr_data_i (cnt_wdata_i),
      .ovf_clr_i (ovf_clr_i),
      .cnt_o     (cnt_o),
      .ovf_o     (ovf_o)
   );

   AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_q.en && !cnt_we_i) |=> $stable(cnt_o)); // R2
   AST_RING_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (!ring_pass && !cnt_we_i) |=> $stable(cnt_o)); // R2
   AST_EDGE_THR0_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_EDGE && cfg_q.edge_det && cfg_q.thr == '0 && !cnt_we_i) |=> $stable(cnt_o)); // R7
   AST_RAW_STEP_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_we_i && !ovf_o && !ovf_clr_i) |=> (cnt_o - $past(cnt_o) <= CNT_W'((1 << OCC_W) - 1))); // R3

endmodule

// File: tb/evt_qual_counter_tb.sv
module evt_qual_counter_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  occ_i = '0;
   logic [1:0]  ring_i = '0;
   logic        cfg_we_i = 1'b0;
   logic [12:0] cfg_wdata_i = '0;
   logic        cnt_we_i = 1'b0;
   logic [47:0] cnt_wdata_i = '0;
   logic        ovf_clr_i = 1'b0;
   logic [47:0] cnt_o;
   logic        ovf_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // model state
   logic [12:0] m_cfg  = '0;
   logic [47:0] m_cnt  = '0;
   logic        m_ovf  = 1'b0;
   logic        m_prev = 1'b0;

   logic [48:0] q_val[$];
   string       q_tag[$];

   always #10 clk = ~clk;

   evt_qual_counter u_dut (
      .clk(clk), .rst_n(rst_n), .occ_i(occ_i), .ring_i(ring_i),
      .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
      .cnt_we_i(cnt_we_i), .cnt_wdata_i(cnt_wdata_i),
      .ovf_clr_i(ovf_clr_i), .cnt_o(cnt_o), .ovf_o(ovf_o)
   );

   task automatic check(input string tag, input logic [47:0] ec, input logic eo);
      n_chk++;
      if (cnt_o !== ec || ovf_o !== eo) begin
         n_bad++;
         $display("FAIL %s: cnt=%0h ovf=%0b expected cnt=%0h ovf=%0b", tag, cnt_o, ovf_o, ec, eo);
      end
   endtask

   task automatic drive(input logic [3:0] o, input logic [1:0] r, input logic cw,
                        input logic [12:0] cv, input logic nw, input logic [47:0] nv,
                        input logic clr, input string tag);
      logic [7:0]  thr;
      logic        cond, qual, pass;
      logic [3:0]  amt;
      logic [48:0] sum;
      @(negedge clk);
      occ_i = o; ring_i = r; cfg_we_i = cw; cfg_wdata_i = cv;
      cnt_we_i = nw; cnt_wdata_i = nv; ovf_clr_i = clr;
      thr  = m_cfg[12:5];
      cond = (thr == 0) ? (o != 0) : ({4'b0, o} >= thr);
      qual = cond ^ m_cfg[3];
      pass = (r == 0) ? m_cfg[2] : m_cfg[1];
      if (m_cfg[4])                   amt = (thr != 0 && qual && !m_prev) ? 4'd1 : 4'd0;
      else if (thr == 0 && !m_cfg[3]) amt = o;
      else                            amt = qual ? 4'd1 : 4'd0;
      if (!m_cfg[0] || !pass) amt = 0;
      m_prev = qual;
      sum = {1'b0, m_cnt} + {45'b0, amt};
      m_ovf = (!nw && sum[48]) || (m_ovf && !clr);
      m_cnt = nw ? nv : sum[47:0];
      if (cw) m_cfg = cv;
      q_val.push_back({m_ovf, m_cnt});
      q_tag.push_back(tag);
   endtask

   task automatic step(input logic [3:0] o, input logic [1:0] r, input string tag);
      drive(o, r, 1'b0, '0, 1'b0, '0, 1'b0, tag);
   endtask

   task automatic set_cfg(input logic [12:0] v, input string tag);
      drive(4'd0, 2'd3, 1'b1, v, 1'b0, '0, 1'b0, tag);
   endtask

   // monitor: compares one queued item per clock, a quarter period after the edge
   initial begin : p_mon
      logic [48:0] ev;
      string       et;
      forever begin
         @(posedge clk);
         #5;
         if (q_val.size() > 0) begin
            ev = q_val.pop_front();
            et = q_tag.pop_front();
            check(et, ev[47:0], ev[48]);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin : p_wdog
      #2_000_000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      finish_run();
   end

   // control word helpers: bit0 en, bit1 usr, bit2 krn, bit3 inv, bit4 edge, [12:5] thr
   function automatic logic [12:0] cw(input logic en, input logic usr, input logic krn,
                                      input logic inv, input logic edg, input logic [7:0] thr);
      return {thr, edg, inv, krn, usr, en};
   endfunction

   initial begin : p_main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R1 reset", 48'd0, 1'b0);
      step(4'd7, 2'd3, "R1 idle cfg");
      step(4'd9, 2'd0, "R1 idle cfg");

      // R3 raw accumulation
      set_cfg(cw(1, 1, 1, 0, 0, 8'd0), "R3 cfg");
      step(4'd5, 2'd3, "R3");
      step(4'd15, 2'd1, "R3");
      step(4'd0, 2'd0, "R3");
      step(4'd3, 2'd2, "R3");

      // R2 ring filter and master enable
      set_cfg(cw(1, 1, 0, 0, 0, 8'd0), "R2 cfg user only");
      step(4'd4, 2'd0, "R2 kernel blocked");
      step(4'd4, 2'd2, "R2 user counts");
      set_cfg(cw(1, 0, 1, 0, 0, 8'd0), "R2 cfg kernel only");
      step(4'd6, 2'd1, "R2 user blocked");
      step(4'd6, 2'd0, "R2 kernel counts");
      set_cfg(cw(0, 1, 1, 0, 0, 8'd0), "R2 cfg disabled");
      step(4'd8, 2'd0, "R2 disabled");
      step(4'd8, 2'd3, "R2 disabled");

      // R4 threshold
      set_cfg(cw(1, 1, 1, 0, 0, 8'd4), "R4 cfg");
      step(4'd3, 2'd3, "R4 below");
      step(4'd4, 2'd3, "R4 equal");
      step(4'd15, 2'd0, "R4 above");
      step(4'd0, 2'd1, "R4 zero");

      // R5 invert
      set_cfg(cw(1, 1, 1, 1, 0, 8'd4), "R5 cfg thr4");
      step(4'd3, 2'd3, "R5 below counts");
      step(4'd4, 2'd3, "R5 equal blocked");
      step(4'd0, 2'd3, "R5 zero counts");
      set_cfg(cw(1, 1, 1, 1, 0, 8'd0), "R5 cfg thr0");
      step(4'd0, 2'd0, "R5 none counts");
      step(4'd2, 2'd0, "R5 some blocked");

      // R6 edge detect
      set_cfg(cw(1, 1, 1, 0, 1, 8'd2), "R6 cfg");
      step(4'd0, 2'd3, "R6 low");
      step(4'd3, 2'd3, "R6 rise");
      step(4'd3, 2'd3, "R6 held");
      step(4'd1, 2'd3, "R6 fall");
      step(4'd5, 2'd3, "R6 rise again");
      step(4'd5, 2'd3, "R6 held again");
      // R6 history across a blocked ring
      set_cfg(cw(1, 1, 0, 0, 1, 8'd2), "R6 cfg user only");
      step(4'd0, 2'd0, "R6 low kernel");
      step(4'd3, 2'd0, "R6 rise while blocked");
      step(4'd3, 2'd3, "R6 no false edge");
      step(4'd0, 2'd3, "R6 low user");
      step(4'd3, 2'd3, "R6 real edge");

      // R7 edge with zero threshold
      set_cfg(cw(1, 1, 1, 0, 1, 8'd0), "R7 cfg");
      step(4'd5, 2'd3, "R7");
      step(4'd0, 2'd3, "R7");
      step(4'd5, 2'd0, "R7");

      // R8 write priority
      set_cfg(cw(1, 1, 1, 0, 0, 8'd0), "R8 cfg");
      drive(4'd5, 2'd3, 1'b0, '0, 1'b1, 48'd1000, 1'b0, "R8 write beats add");
      step(4'd2, 2'd3, "R8 after write");

      // R9 overflow
      drive(4'd5, 2'd3, 1'b0, '0, 1'b1, 48'hFFFF_FFFF_FFFD, 1'b0, "R9 preload");
      step(4'd5, 2'd3, "R9 wrap");
      step(4'd0, 2'd3, "R9 sticky");
      drive(4'd0, 2'd3, 1'b0, '0, 1'b1, 48'hFFFF_FFFF_FFFF, 1'b0, "R9 write no set");
      drive(4'd0, 2'd3, 1'b0, '0, 1'b0, '0, 1'b1, "R9 clear");
      drive(4'd1, 2'd3, 1'b0, '0, 1'b0, '0, 1'b1, "R9 set beats clear");
      drive(4'd0, 2'd3, 1'b0, '0, 1'b0, '0, 1'b1, "R9 clear again");

      while (q_val.size() > 0) @(negedge clk);
      @(negedge clk);
      finish_run();
   end

endmodule